// File: doc/BRIEF.md
# Balanced Dual-Mono Serial DAC Feeder

This block accepts a stereo serial audio stream (bit clock, word select, serial data) and feeds four 16-bit serial-input DACs that are wired as two differential pairs, one pair per channel. Each channel gets a true data line and a bitwise-inverted data line. All four DACs share one bit clock and one latch-enable strobe.

Every input is re-registered on the local master clock before use. This includes the incoming bit clock, so input rates well below the DAC clock are sampled correctly. The DAC bit clock is the master clock divided by two. The left word of a frame is held back until its right word has arrived, and then both are shifted out together.

The serial input is paced entirely by its source and cannot be stalled, so it has no valid/ready handshake and no back-pressure. If a new frame completes while the previous one is still being shifted out, the newer frame replaces the one waiting to be sent. Control pins are plain levels.

Top module: `balanced_dac_feeder`

## Requirements
- R1: While `rst_n` is low, `dac_le` is 1 and `dac_bclk`, `left_p`, `left_n`, `right_p` and `right_n` are all 0 (from the first clock edge of reset onward).
- R2: While `out_en` is 1, `dac_bclk` toggles on every master clock edge (master/2). One cycle after `out_en` is seen low, `dac_bclk` stays 0.
- R3: `i2s_bclk`, `i2s_ws` and `i2s_sd` are retimed through two master-clock register stages. Input bits are taken on rising edges of the retimed input bit clock, which works for input bit clocks of at most master/4, including rates that are not integer fractions of master/2.
- R4: Input framing: `i2s_ws`=0 marks the left slot and `i2s_ws`=1 marks the right slot. The MSB arrives one input bit after the word-select change. Only the 16 most significant bits of each slot are forwarded, MSB first, two's complement.
- R5: For each channel, `*_p` carries the word unchanged and `*_n` carries its bitwise inverse.
- R6: A left word is held until the right word of the same frame completes. Both are then sent in the same 16-bit burst, followed by exactly one latch-enable pulse per frame.
- R7: Output data changes only on falling edges of `dac_bclk`, so it is stable at each rising edge. After the 16th bit, `dac_le` goes low for exactly one `dac_bclk` period (2 master cycles), falling together with `dac_bclk`.
- R8: If no word-select change is seen for `WS_LOSS_CYCLES` master cycles, all four data lines are forced to 0 until the next word-select change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local master clock (22.5792 or 24.576 MHz) |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| i2s_bclk | input | 1 | Incoming serial bit clock, asynchronous |
| i2s_ws | input | 1 | Incoming word select (0 left, 1 right) |
| i2s_sd | input | 1 | Incoming serial data, MSB first |
| out_en | input | 1 | Clock distribution enable; 0 stops `dac_bclk` |
| dac_bclk | output | 1 | DAC bit clock, master/2 |
| dac_le | output | 1 | DAC latch enable, low for one period after each word |
| left_p | output | 1 | Left channel true data |
| left_n | output | 1 | Left channel inverted data |
| right_p | output | 1 | Right channel true data |
| right_n | output | 1 | Right channel inverted data |

## Verification
An input bit appears inside the block three master cycles after its input bit-clock edge: two retime stages plus the edge register. A completed frame starts shifting on the next falling-edge tick of the divider, and every output leaves through one shared register, so `dac_bclk`, `dac_le` and data move in the same cycle. `out_en` reaches `dac_bclk` one cycle later, and the loss condition appears `WS_LOSS_CYCLES` plus three cycles after the last word-select change. The bench avoids exact cycle counting for words. It models the DACs at the ports: it shifts data on rising `dac_bclk`, captures words on falling `dac_le`, and times the pulse width. All other checks are sampled on the falling master clock edge after waits longer than those latencies.

// File: rtl/bdf_pkg.sv
`timescale 1ns/1ps
package bdf_pkg;
  typedef struct packed {
    logic bclk;
    logic ws;
    logic sd;
  } ser_t;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_LATCH = 2'd2
  } tx_state_e;
endpackage

// File: rtl/bdf_retime.sv
`timescale 1ns/1ps
module bdf_retime #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[g] <= '0;
      else if (g == 0) stg[g] <= d;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bdf_rx.sv
`timescale 1ns/1ps
module bdf_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              ws,
  input  logic              sd,
  output logic              frame_vld,
  output logic [WORD_W-1:0] frame_l,
  output logic [WORD_W-1:0] frame_r
);
  localparam int IDX_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh, left_hold, done_word;
  logic [IDX_W-1:0]  idx;
  logic              ws_prev;

  // a slot of exactly WORD_W bits ends with its LSB on the select-change bit
  always_comb
    done_word = (idx < IDX_W'(WORD_W)) ? {sh[WORD_W-2:0], sd} : sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '0;
      left_hold <= '0;
      idx       <= '0;
      ws_prev   <= 1'b0;
      frame_vld <= 1'b0;
      frame_l   <= '0;
      frame_r   <= '0;
    end else begin
      frame_vld <= 1'b0;
      if (bit_stb) begin
        ws_prev <= ws;
        if (ws != ws_prev) begin
          idx <= '0;
          if (!ws_prev) begin
            left_hold <= done_word;
          end else begin
            frame_l   <= left_hold;
            frame_r   <= done_word;
            frame_vld <= 1'b1;
          end
        end else if (idx < IDX_W'(WORD_W)) begin
          sh  <= {sh[WORD_W-2:0], sd};
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bdf_tx.sv
`timescale 1ns/1ps
module bdf_tx
  import bdf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              frame_vld,
  input  logic [WORD_W-1:0] frame_l,
  input  logic [WORD_W-1:0] frame_r,
  output logic              bit_l,
  output logic              bit_r,
  output logic              le
);
  localparam int CNT_W = $clog2(WORD_W);

  tx_state_e         state;
  logic [WORD_W-1:0] hold_l, hold_r, sh_l, sh_r;
  logic [CNT_W-1:0]  cnt;
  logic              pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= TX_IDLE;
      hold_l <= '0;
      hold_r <= '0;
      sh_l   <= '0;
      sh_r   <= '0;
      cnt    <= '0;
      pend   <= 1'b0;
      le     <= 1'b1;
    end else begin
      if (tick) begin
        unique case (state)
          TX_IDLE: if (pend) begin
            sh_l  <= hold_l;
            sh_r  <= hold_r;
            cnt   <= '0;
            pend  <= 1'b0;
            state <= TX_SHIFT;
          end
          TX_SHIFT: if (cnt == CNT_W'(WORD_W-1)) begin
            le    <= 1'b0;
            state <= TX_LATCH;
          end else begin
            cnt  <= cnt + 1'b1;
            sh_l <= {sh_l[WORD_W-2:0], 1'b0};
            sh_r <= {sh_r[WORD_W-2:0], 1'b0};
          end
          TX_LATCH: begin
            le    <= 1'b1;
            state <= TX_IDLE;
          end
          default: state <= TX_IDLE;
        endcase
      end
      if (frame_vld) begin
        hold_l <= frame_l;
        hold_r <= frame_r;
        pend   <= 1'b1;
      end
    end
  end

  assign bit_l = sh_l[WORD_W-1];
  assign bit_r = sh_r[WORD_W-1];
endmodule

// File: rtl/balanced_dac_feeder.sv
`timescale 1ns/1ps
module balanced_dac_feeder
  import bdf_pkg::*;
#(
  parameter int WORD_W         = 16,
  parameter int SYNC_STAGES    = 2,
  parameter int WS_LOSS_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i2s_bclk,
  input  logic i2s_ws,
  input  logic i2s_sd,
  input  logic out_en,
  output logic dac_bclk,
  output logic dac_le,
  output logic left_p,
  output logic left_n,
  output logic right_p,
  output logic right_n
);
  localparam int LOSS_W = $clog2(WS_LOSS_CYCLES + 1);

  ser_t raw, rs;
  logic bclk_d, ws_d, bit_stb, ws_chg;
  logic half, lost;
  logic [LOSS_W-1:0] loss_cnt;
  logic frame_vld, bit_l, bit_r, tx_le;
  logic [WORD_W-1:0] frame_l, frame_r;

  assign raw = '{bclk: i2s_bclk, ws: i2s_ws, sd: i2s_sd};

  bdf_retime #(.W($bits(ser_t)), .STAGES(SYNC_STAGES)) u_retime (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(rs)
  );

  // edge detection: one more stage behind the retimed outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_d <= 1'b0;
      ws_d   <= 1'b0;
    end else begin
      bclk_d <= rs.bclk;
      ws_d   <= rs.ws;
    end
  end
  assign bit_stb = rs.bclk & ~bclk_d;
  assign ws_chg  = rs.ws ^ ws_d;

  // word-select loss watchdog, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) loss_cnt <= '0;
    else if (ws_chg) loss_cnt <= '0;
    else if (loss_cnt != LOSS_W'(WS_LOSS_CYCLES)) loss_cnt <= loss_cnt + 1'b1;
  end
  assign lost = (loss_cnt == LOSS_W'(WS_LOSS_CYCLES));

  // master/2 divider; tick when the DAC clock is about to fall
  always_ff @(posedge clk) begin
    if (!rst_n) half <= 1'b0;
    else half <= ~half;
  end

  bdf_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .ws(rs.ws), .sd(rs.sd),
    .frame_vld(frame_vld), .frame_l(frame_l), .frame_r(frame_r)
  );

  bdf_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(half), .frame_vld(frame_vld),
    .frame_l(frame_l), .frame_r(frame_r),
    .bit_l(bit_l), .bit_r(bit_r), .le(tx_le)
  );

  // single shared output stage: clock, strobe and both polarities of data
  // leave through the same register so their delays match
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_bclk <= 1'b0;
      dac_le   <= 1'b1;
      left_p   <= 1'b0;
      left_n   <= 1'b0;
      right_p  <= 1'b0;
      right_n  <= 1'b0;
    end else begin
      dac_bclk <= half & out_en;
      dac_le   <= tx_le;
      left_p   <= ~lost & bit_l;
      left_n   <= ~lost & ~bit_l;
      right_p  <= ~lost & bit_r;
      right_n  <= ~lost & ~bit_r;
    end
  end
endmodule

// File: rtl/bdf_checker.sv
`timescale 1ns/1ps
module bdf_checker (
  input logic clk,
  input logic rst_n,
  input logic out_en,
  input logic dac_bclk,
  input logic dac_le,
  input logic left_p,
  input logic left_n,
  input logic right_p,
  input logic right_n
);
  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((left_p ^ left_n) && (right_p ^ right_n)) ||
    (!left_p && !left_n && !right_p && !right_n)); // R5

  AST_CLOCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !dac_bclk); // R2

  AST_LE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_le) |=> !dac_le); // R7

  AST_LE_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_le && $past(!dac_le)) |=> dac_le); // R7

  AST_LE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dac_le) && $past(out_en) && $past(out_en, 2)) |-> $fell(dac_bclk)); // R7

  AST_DATA_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dac_bclk) && (left_p | left_n) && $past(left_p | left_n))
      |-> ($stable(left_p) && $stable(right_p))); // R7
endmodule

bind balanced_dac_feeder bdf_checker u_chk (.*);

// File: tb/balanced_dac_feeder_tb.sv
`timescale 1ns/1ps
module balanced_dac_feeder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int LOSS       = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic i2s_bclk = 1'b0, i2s_ws = 1'b0, i2s_sd = 1'b0, out_en = 1'b1;
  logic dac_bclk, dac_le, left_p, left_n, right_p, right_n;

  int checks = 0, fails = 0, cyc = 0;
  int le_cnt = 0, rises_low = 0, bclk_rises = 0;
  time t_fall = 0, t_rise = 0;
  logic [15:0] s_lp = '0, s_ln = '0, s_rp = '0, s_rn = '0;
  logic [15:0] g_lp = '0, g_ln = '0, g_rp = '0, g_rn = '0;

  balanced_dac_feeder #(.WS_LOSS_CYCLES(LOSS)) u_dut (
    .clk(clk), .rst_n(rst_n), .i2s_bclk(i2s_bclk), .i2s_ws(i2s_ws),
    .i2s_sd(i2s_sd), .out_en(out_en), .dac_bclk(dac_bclk), .dac_le(dac_le),
    .left_p(left_p), .left_n(left_n), .right_p(right_p), .right_n(right_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog R1..: cycles=%0d expected below %0d", cyc, WATCHDOG);
      report();
    end
  end

  // DAC model at the ports
  always @(posedge dac_bclk) begin
    bclk_rises++;
    if (!dac_le) rises_low++;
    s_lp <= {s_lp[14:0], left_p};
    s_ln <= {s_ln[14:0], left_n};
    s_rp <= {s_rp[14:0], right_p};
    s_rn <= {s_rn[14:0], right_n};
  end
  always @(negedge dac_le) begin
    g_lp = s_lp; g_ln = s_ln; g_rp = s_rp; g_rn = s_rn;
    t_fall = $time; rises_low = 0; le_cnt++;
  end
  always @(posedge dac_le) t_rise = $time;

  task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic ws, input logic d, input int h);
    i2s_bclk = 1'b0; i2s_ws = ws; i2s_sd = d;
    repeat (h) @(negedge clk);
    i2s_bclk = 1'b1;
    repeat (h) @(negedge clk);
  endtask

  task automatic send_frame(input [31:0] l, input [31:0] r, input int h);
    for (int i = 0; i < 32; i++) send_bit(i == 31, l[31-i], h);
    for (int i = 0; i < 32; i++) send_bit(i != 31, r[31-i], h);
  endtask

  // one frame end to end; h = input half bit in master cycles
  task automatic t_frame(input [31:0] l, input [31:0] r, input int h, input string rq);
    int c0 = le_cnt;
    send_frame(l, r, h);
    for (int k = 0; k < 300 && le_cnt == c0; k++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(g_lp == l[31:16], {rq, " R4 left true word"}, g_lp, l[31:16]);
    chk(g_ln == ~l[31:16], "R5 left inverted word", g_ln, ~l[31:16]);
    chk(g_rp == r[31:16], "R6 right word paired with left", g_rp, r[31:16]);
    chk(g_rn == ~r[31:16], "R5 right inverted word", g_rn, ~r[31:16]);
    chk(le_cnt - c0 == 1, "R6 one strobe per frame", le_cnt - c0, 1);
    chk(t_rise - t_fall == 2*CLK_PERIOD, "R7 strobe width", 32'(t_rise - t_fall), 2*CLK_PERIOD);
    chk(rises_low == 1, "R7 one clock rise while strobe low", rises_low, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(dac_le == 1'b1, "R1 strobe high in reset", dac_le, 1);
    chk(dac_bclk == 1'b0, "R1 clock low in reset", dac_bclk, 0);
    chk({left_p, left_n, right_p, right_n} == 4'b0, "R1 data low in reset",
        {left_p, left_n, right_p, right_n}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_enable();
    int r0;
    out_en = 1'b0;
    repeat (2) @(negedge clk);
    r0 = bclk_rises;
    repeat (40) @(negedge clk);
    chk(bclk_rises == r0, "R2 no clock while disabled", bclk_rises - r0, 0);
    out_en = 1'b1;
    repeat (2) @(negedge clk);
    r0 = bclk_rises;
    repeat (40) @(negedge clk);
    chk(bclk_rises - r0 == 20, "R2 master/2 rate when enabled", bclk_rises - r0, 20);
  endtask

  task automatic t_loss();
    logic bad = 1'b0;
    chk((left_p ^ left_n) == 1'b1, "R8 lines live before loss", left_p ^ left_n, 1);
    repeat (LOSS + 60) @(negedge clk);
    for (int k = 0; k < 30; k++) begin
      if (left_p | left_n | right_p | right_n) bad = 1'b1;
      @(negedge clk);
    end
    chk(bad == 1'b0, "R8 all data forced low on select loss", bad, 0);
    t_frame(32'h5A5A_0F0F, 32'hC3C3_F0F0, 2, "R8 recovery");
  endtask

  initial begin
    t_reset();
    t_frame(32'hA5C3_0001, 32'h3C96_8000, 2, "R4");
    t_frame(32'h8000_FFFF, 32'h7FFF_0000, 2, "R4 extremes");
    t_frame(32'h0000_0000, 32'hFFFF_FFFF, 2, "R6");
    t_frame(32'h1234_5678, 32'hFEDC_BA98, 3, "R3 slower input clock");
    t_frame(32'h0F0F_1111, 32'hF0F0_2222, 5, "R3 odd-ratio input clock");
    t_enable();
    t_loss();
    report();
  end
endmodule